// File: doc/BRIEF.md
# Configurable Interrupt Source Conditioner

This block takes a parameterised set of external interrupt lines (up to 256) and turns each into a clean pending bit. Every line has its own configuration: sensing mode (level or edge), polarity, and a dual-edge option. Each line passes through a synchroniser. A level-sensed line's pending bit tracks the polarity-corrected input. An edge-sensed line's pending bit comes from a two-state latch per line, which holds the pending state until software clears it.

Software programs the block through a 32-bit word-addressed register port. Configuration and mask banks hold one bit per line, with 32 lines packed into each word. The mask can only be changed through a set register and a clear register, each of which acts on the bits written as 1. A single software-trigger register takes an 8-bit line number and a set/clear flag, so software can raise or drop the pending state of an edge-sensed line. The output vector is each line's pending bit gated by its mask bit. Routing to processors is done further downstream.

Each line's edge latch is a state machine with two states. In `LN_QUIET` nothing is latched. In `LN_LATCHED` the line is pending. Its transitions are:
- arm: `LN_QUIET` to `LN_LATCHED`, taken on a qualifying edge or a software set.
- release: `LN_LATCHED` to `LN_QUIET`, taken on a software clear when no edge arrives in the same cycle.
- flush: any state to `LN_QUIET`, taken while the line is level-sensed.

Top module: `isc_top`

## Requirements
- R1: Reset clears every configuration bit and every mask bit and puts every edge latch in `LN_QUIET`, so that `irq_out` is all zero while reset is held and right after it.
- R2: Line n occupies bit n%32 of the word at byte offset 4*(n/32) in each bit-per-line bank. The banks are polarity at 0x100, sensing mode at 0x180 and dual-edge at 0x200, and all three can be read and written. Bits with no line behind them read 0, and so do words past the last line.
- R3: A line with mode bit 0 (level) is pending while its synchronised input equals its polarity bit (1 = active-high, 0 = active-low), and it latches nothing.
- R4: A line with mode bit 1 and dual bit 0 latches pending on a rising edge when polarity is 1, or on a falling edge when polarity is 0. The opposite edge is ignored, and the pending state holds after the input returns.
- R5: A line with mode bit 1 and dual bit 1 latches pending on either edge, whatever its polarity.
- R6: A write to 0x280 with bit 31 = 1 sets, and with bit 31 = 0 clears, the latch of the edge-sensed line numbered by bits 7:0. Numbers at or above the line count, and level-sensed lines, are left unaffected.
- R7: If a qualifying edge and a software clear reach the same line in the same cycle, the line ends up pending.
- R8: Writing 1s to 0x380 sets the matching mask bits and writing 1s to 0x300 clears them. Mask bits written as 0 keep their value.
- R9: The mask reads back at 0x400 and the pending state at 0x480. Writes to either address change nothing.
- R10: Each bit of `irq_out` is the line's pending bit ANDed with its mask bit.
- R11: Switching a line to level sensing discards its latched state, so switching it back to edge sensing starts from `LN_QUIET`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | NUM_LINES | Raw interrupt inputs, asynchronous to clk |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_out | output | NUM_LINES | Masked pending interrupts |

## Verification
The bench drives a software clear into the exact cycle in which a synchronised rising edge is detected. A design that lets the clear win would lose that interrupt. The bench checks that the opposite edge of a single-edge line is ignored, and that both edges of a dual-edge line are caught. A detector that ignores polarity or the dual setting would show up as wrong or missing pending bits. Software-trigger writes aimed at level-sensed lines, or at line numbers beyond the line count, must leave every output unchanged; a decoder that aliases the 8-bit number or skips the mode check would disturb other lines. The bench also goes after mode round-trips that must flush a stale latch, read-back of the partial last word, and writes to the read-only views.

// File: rtl/isc_pkg.sv
package isc_pkg;

    // Register port geometry
    localparam int REG_ADDR_W  = 12;
    localparam int REG_DATA_W  = 32;
    localparam int BANK_LSB    = 7;
    localparam int BANK_W      = REG_ADDR_W - BANK_LSB;
    localparam int WORD_LSB    = 2;
    localparam int WORD_W      = BANK_LSB - WORD_LSB;

    // Bank codes taken from bus_addr[11:7]
    localparam logic [BANK_W-1:0] BANK_POL   = 5'd2;  // 0x100
    localparam logic [BANK_W-1:0] BANK_MODE  = 5'd3;  // 0x180
    localparam logic [BANK_W-1:0] BANK_DUAL  = 5'd4;  // 0x200
    localparam logic [BANK_W-1:0] BANK_SWTRG = 5'd5;  // 0x280
    localparam logic [BANK_W-1:0] BANK_MCLR  = 5'd6;  // 0x300
    localparam logic [BANK_W-1:0] BANK_MSET  = 5'd7;  // 0x380
    localparam logic [BANK_W-1:0] BANK_MVIEW = 5'd8;  // 0x400
    localparam logic [BANK_W-1:0] BANK_PVIEW = 5'd9;  // 0x480

    // Software trigger word fields
    localparam int SWTRG_SET_BIT = 31;
    localparam int SWTRG_NUM_W   = 8;

    typedef enum logic {
        LN_QUIET   = 1'b0,
        LN_LATCHED = 1'b1
    } line_state_e;

endpackage

// File: rtl/isc_sync.sv
module isc_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/isc_line.sv
module isc_line
    import isc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    input  logic cfg_pol,
    input  logic cfg_edge,
    input  logic cfg_dual,
    input  logic sw_set,
    input  logic sw_clr,
    output logic pend
);

    line_state_e st_q, st_d;
    logic        prev_q;
    logic        rise, fall, hit;

    // Previous synchronised sample for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_in;
    end

    assign rise = sync_in & ~prev_q;
    assign fall = ~sync_in & prev_q;
    assign hit  = cfg_dual ? (rise | fall) : (cfg_pol ? rise : fall);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LN_QUIET;
        else        st_q <= st_d;
    end

    // Next state: flush while level, arm on edge or set, release on clear
    always_comb begin
        st_d = st_q;
        if (!cfg_edge) begin
            st_d = LN_QUIET;
        end else begin
            unique case (st_q)
                LN_QUIET:   if (hit || sw_set)  st_d = LN_LATCHED;
                LN_LATCHED: if (sw_clr && !hit) st_d = LN_QUIET;
                default:    st_d = LN_QUIET;
            endcase
        end
    end

    // Output: latch for edge lines, polarity-matched input for level lines
    always_comb begin
        if (cfg_edge) pend = (st_q == LN_LATCHED);
        else          pend = (sync_in == cfg_pol);
    end

endmodule

// File: rtl/isc_regfile.sv
module isc_regfile
    import isc_pkg::*;
#(
    parameter int NUM_LINES = 40
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [REG_DATA_W-1:0] bus_wdata,
    output logic [REG_DATA_W-1:0] bus_rdata,
    input  logic [NUM_LINES-1:0]  pend_vec,
    output logic [NUM_LINES-1:0]  pol_vec,
    output logic [NUM_LINES-1:0]  trig_vec,
    output logic [NUM_LINES-1:0]  dual_vec,
    output logic [NUM_LINES-1:0]  mask_vec,
    output logic [NUM_LINES-1:0]  sw_set_vec,
    output logic [NUM_LINES-1:0]  sw_clr_vec
);

    localparam int NUM_WORDS = (NUM_LINES + REG_DATA_W - 1) / REG_DATA_W;
    localparam int PAD_W     = NUM_WORDS * REG_DATA_W;
    localparam int IDX_W     = WORD_W + 5;

    logic [BANK_W-1:0] bank_sel;
    logic [WORD_W-1:0] word_sel;
    logic              word_ok;
    logic              swtrg_wr;
    logic [SWTRG_NUM_W-1:0] swtrg_num;

    assign bank_sel  = bus_addr[REG_ADDR_W-1:BANK_LSB];
    assign word_sel  = bus_addr[BANK_LSB-1:WORD_LSB];
    assign word_ok   = ({{(32-WORD_W){1'b0}}, word_sel} < 32'(NUM_WORDS));
    assign swtrg_wr  = bus_wr && (bank_sel == BANK_SWTRG);
    assign swtrg_num = bus_wdata[SWTRG_NUM_W-1:0];

    // Per-line configuration and mask storage
    generate
        for (genvar j = 0; j < NUM_LINES; j++) begin : g_bit
            localparam int W = j / REG_DATA_W;
            localparam int B = j % REG_DATA_W;
            logic hit_word;
            assign hit_word = bus_wr && (word_sel == WORD_W'(W));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pol_vec[j]  <= 1'b0;
                    trig_vec[j] <= 1'b0;
                    dual_vec[j] <= 1'b0;
                    mask_vec[j] <= 1'b0;
                end else if (hit_word) begin
                    if (bank_sel == BANK_POL)  pol_vec[j]  <= bus_wdata[B];
                    if (bank_sel == BANK_MODE) trig_vec[j] <= bus_wdata[B];
                    if (bank_sel == BANK_DUAL) dual_vec[j] <= bus_wdata[B];
                    if (bank_sel == BANK_MCLR && bus_wdata[B]) mask_vec[j] <= 1'b0;
                    if (bank_sel == BANK_MSET && bus_wdata[B]) mask_vec[j] <= 1'b1;
                end
            end

            // Software trigger decode for this line
            assign sw_set_vec[j] = swtrg_wr && (swtrg_num == SWTRG_NUM_W'(j))
                                   && bus_wdata[SWTRG_SET_BIT];
            assign sw_clr_vec[j] = swtrg_wr && (swtrg_num == SWTRG_NUM_W'(j))
                                   && !bus_wdata[SWTRG_SET_BIT];
        end
    endgenerate

    // Read-back mux
    logic [PAD_W-1:0] src_pad;
    logic [IDX_W-1:0] base_idx;

    assign base_idx = {word_sel, 5'b0};

    always_comb begin
        case (bank_sel)
            BANK_POL:   src_pad = PAD_W'(pol_vec);
            BANK_MODE:  src_pad = PAD_W'(trig_vec);
            BANK_DUAL:  src_pad = PAD_W'(dual_vec);
            BANK_MVIEW: src_pad = PAD_W'(mask_vec);
            BANK_PVIEW: src_pad = PAD_W'(pend_vec);
            default:    src_pad = '0;
        endcase
        bus_rdata = '0;
        if (word_ok) bus_rdata = src_pad[base_idx +: REG_DATA_W];
    end

endmodule

// File: rtl/isc_top.sv
module isc_top
    import isc_pkg::*;
#(
    parameter int NUM_LINES   = 40,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_LINES-1:0]  irq_in,
    input  logic                  bus_wr,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [REG_DATA_W-1:0] bus_wdata,
    output logic [REG_DATA_W-1:0] bus_rdata,
    output logic [NUM_LINES-1:0]  irq_out
);

    logic [NUM_LINES-1:0] sync_vec;
    logic [NUM_LINES-1:0] pend_vec;
    logic [NUM_LINES-1:0] pol_vec;
    logic [NUM_LINES-1:0] trig_vec;
    logic [NUM_LINES-1:0] dual_vec;
    logic [NUM_LINES-1:0] mask_vec;
    logic [NUM_LINES-1:0] sw_set_vec;
    logic [NUM_LINES-1:0] sw_clr_vec;

    isc_sync #(
        .WIDTH  (NUM_LINES),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (irq_in),
        .sync_out (sync_vec)
    );

    isc_regfile #(
        .NUM_LINES (NUM_LINES)
    ) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .pend_vec   (pend_vec),
        .pol_vec    (pol_vec),
        .trig_vec   (trig_vec),
        .dual_vec   (dual_vec),
        .mask_vec   (mask_vec),
        .sw_set_vec (sw_set_vec),
        .sw_clr_vec (sw_clr_vec)
    );

    generate
        for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
            isc_line line_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .sync_in  (sync_vec[n]),
                .cfg_pol  (pol_vec[n]),
                .cfg_edge (trig_vec[n]),
                .cfg_dual (dual_vec[n]),
                .sw_set   (sw_set_vec[n]),
                .sw_clr   (sw_clr_vec[n]),
                .pend     (pend_vec[n])
            );
        end
    endgenerate

    assign irq_out = pend_vec & mask_vec;

endmodule

// File: rtl/isc_checker.sv
module isc_checker
    import isc_pkg::*;
#(
    parameter int NUM_LINES = 40
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_wr,
    input logic [REG_ADDR_W-1:0] bus_addr,
    input logic [REG_DATA_W-1:0] bus_wdata,
    input logic [NUM_LINES-1:0]  irq_out,
    input logic [NUM_LINES-1:0]  mask_vec,
    input logic [NUM_LINES-1:0]  pend_vec,
    input logic [NUM_LINES-1:0]  trig_vec,
    input logic [NUM_LINES-1:0]  sw_set_vec,
    input logic [NUM_LINES-1:0]  sw_clr_vec
);

    logic mode_wr;
    assign mode_wr = bus_wr && (bus_addr == 12'h180);

    AST_MCLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 12'h300 && bus_wdata[0]) |=> (!mask_vec[0] && !irq_out[0])); // R8

    AST_MSET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 12'h380 && bus_wdata[0]) |=> mask_vec[0]); // R8

    AST_SWSET_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_set_vec[0] && trig_vec[0]) |=> pend_vec[0]); // R6

    AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_vec[0] && pend_vec[0] && !sw_clr_vec[0] && !mode_wr) |=> pend_vec[0]); // R4

    AST_SWTRG_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sw_set_vec | sw_clr_vec)); // R6

    AST_SWTRG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 12'h280 && ({24'd0, bus_wdata[7:0]} >= 32'(NUM_LINES)))
        |-> (sw_set_vec == '0 && sw_clr_vec == '0)); // R6

endmodule

bind isc_top isc_checker #(.NUM_LINES(NUM_LINES)) chk_i (.*);

// File: tb/isc_top_tb_top.sv
module isc_top_tb_top;

    localparam int NL     = 40;
    localparam int STAGES = 2;

    localparam logic [3:0] OP_WR  = 4'd0;
    localparam logic [3:0] OP_RD  = 4'd1;
    localparam logic [3:0] OP_IN  = 4'd2;
    localparam logic [3:0] OP_OUT = 4'd3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] irq_in = '0;
    logic          bus_wr = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NL-1:0] irq_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    isc_top #(.NUM_LINES(NL), .SYNC_STAGES(STAGES)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    function automatic logic [83:0] mkv(logic [3:0] op, logic [3:0] rq,
                                        logic [11:0] a, logic [31:0] d, logic [31:0] e);
        return {op, rq, a, d, e};
    endfunction

    localparam int NV = 40;
    localparam logic [83:0] VECS [NV] = '{
        mkv(OP_RD,  4'd1,  12'h400, 32'h0,        32'h0),        // R1 mask clear
        mkv(OP_RD,  4'd1,  12'h100, 32'h0,        32'h0),        // R1 polarity clear
        mkv(OP_OUT, 4'd1,  12'h000, 32'h0,        32'h0),        // R1 outputs low
        mkv(OP_WR,  4'd8,  12'h380, 32'hFFFFFFFF, 32'h0),        // R8 set all
        mkv(OP_RD,  4'd8,  12'h400, 32'h0,        32'hFFFFFFFF), // R8
        mkv(OP_OUT, 4'd3,  12'h000, 32'h0,        32'hFFFFFFFF), // R3 active-low idle
        mkv(OP_WR,  4'd8,  12'h300, 32'h0000FFFF, 32'h0),        // R8 clear low half
        mkv(OP_RD,  4'd8,  12'h400, 32'h0,        32'hFFFF0000), // R8
        mkv(OP_OUT, 4'd10, 12'h000, 32'h0,        32'hFFFF0000), // R10
        mkv(OP_WR,  4'd8,  12'h380, 32'h0000FFFF, 32'h0),        // R8
        mkv(OP_WR,  4'd2,  12'h100, 32'h000000FF, 32'h0),        // R2
        mkv(OP_RD,  4'd2,  12'h100, 32'h0,        32'h000000FF), // R2
        mkv(OP_OUT, 4'd3,  12'h000, 32'h0,        32'hFFFFFF00), // R3 active-high idle
        mkv(OP_IN,  4'd3,  12'h000, 32'h0000000F, 32'h0),
        mkv(OP_OUT, 4'd3,  12'h000, 32'h0,        32'hFFFFFF0F), // R3
        mkv(OP_IN,  4'd3,  12'h000, 32'h00000000, 32'h0),
        mkv(OP_WR,  4'd4,  12'h180, 32'h000000FF, 32'h0),
        mkv(OP_WR,  4'd5,  12'h200, 32'h000000F0, 32'h0),
        mkv(OP_OUT, 4'd4,  12'h000, 32'h0,        32'hFFFFFF00), // R4 no edge yet
        mkv(OP_IN,  4'd4,  12'h000, 32'h00000011, 32'h0),
        mkv(OP_OUT, 4'd4,  12'h000, 32'h0,        32'hFFFFFF11), // R4 R5 rising
        mkv(OP_IN,  4'd4,  12'h000, 32'h00000000, 32'h0),
        mkv(OP_OUT, 4'd4,  12'h000, 32'h0,        32'hFFFFFF11), // R4 held
        mkv(OP_WR,  4'd4,  12'h100, 32'h000000FB, 32'h0),
        mkv(OP_IN,  4'd4,  12'h000, 32'h00000004, 32'h0),
        mkv(OP_OUT, 4'd4,  12'h000, 32'h0,        32'hFFFFFF11), // R4 wrong edge ignored
        mkv(OP_IN,  4'd4,  12'h000, 32'h00000000, 32'h0),
        mkv(OP_OUT, 4'd4,  12'h000, 32'h0,        32'hFFFFFF15), // R4 falling
        mkv(OP_IN,  4'd5,  12'h000, 32'h00000060, 32'h0),
        mkv(OP_OUT, 4'd5,  12'h000, 32'h0,        32'hFFFFFF75), // R5 rising
        mkv(OP_WR,  4'd6,  12'h280, 32'h00000006, 32'h0),
        mkv(OP_OUT, 4'd6,  12'h000, 32'h0,        32'hFFFFFF35), // R6 clear
        mkv(OP_IN,  4'd5,  12'h000, 32'h00000020, 32'h0),
        mkv(OP_OUT, 4'd5,  12'h000, 32'h0,        32'hFFFFFF75), // R5 falling
        mkv(OP_WR,  4'd6,  12'h280, 32'h80000003, 32'h0),
        mkv(OP_OUT, 4'd6,  12'h000, 32'h0,        32'hFFFFFF7D), // R6 set
        mkv(OP_WR,  4'd6,  12'h280, 32'h00000000, 32'h0),
        mkv(OP_OUT, 4'd6,  12'h000, 32'h0,        32'hFFFFFF7C), // R6 clear line 0
        mkv(OP_WR,  4'd6,  12'h280, 32'h00000008, 32'h0),
        mkv(OP_OUT, 4'd6,  12'h000, 32'h0,        32'hFFFFFF7C)  // R6 level line untouched
    };

    task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(string rq, logic [11:0] a, logic [31:0] e);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(rq, bus_rdata, e);
    endtask

    task automatic settle();
        repeat (6) @(posedge clk);
    endtask

    task automatic finish_up();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        finish_up();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", irq_out[31:0], 32'h0);
        rst_n = 1'b1;
        settle();

        for (int i = 0; i < NV; i++) begin
            logic [3:0]  op;
            logic [3:0]  rq;
            logic [11:0] a;
            logic [31:0] d;
            logic [31:0] e;
            string       tag;
            {op, rq, a, d, e} = VECS[i];
            tag = $sformatf("R%0d vec%0d", rq, i);
            case (op)
                OP_WR:  begin wr(a, d); settle(); end
                OP_RD:  rd_chk(tag, a, e);
                OP_IN:  begin @(negedge clk); irq_in[31:0] = d; settle(); end
                default: begin @(negedge clk); check(tag, irq_out[31:0], e); end
            endcase
        end

        // R6: out-of-range number leaves everything alone
        wr(12'h280, 32'h800000FF); settle();
        @(negedge clk); check("R6 range", irq_out[31:0], 32'hFFFFFF7C);
        rd_chk("R6 range word1", 12'h484, 32'h000000FF);

        // R9: read-only views ignore writes
        wr(12'h400, 32'h0); settle();
        rd_chk("R9 mask view", 12'h400, 32'hFFFFFFFF);
        wr(12'h480, 32'h0); settle();
        rd_chk("R9 pend view", 12'h480, 32'hFFFFFF7C);

        // R2: partial last word and missing words
        wr(12'h104, 32'hFFFFFFFF); settle();
        rd_chk("R2 partial word", 12'h104, 32'h000000FF);
        rd_chk("R2 missing word", 12'h108, 32'h0);
        rd_chk("R3 word1 active-high", 12'h484, 32'h0);

        // R11: level round-trip flushes the latch of line 3
        wr(12'h180, 32'h000000F7); settle();
        @(negedge clk); check("R11 level", irq_out[31:0], 32'hFFFFFF74);
        wr(12'h180, 32'h000000FF); settle();
        @(negedge clk); check("R11 back to edge", irq_out[31:0], 32'hFFFFFF74);

        // R7: rising edge on line 0 meets a software clear in the same cycle
        @(negedge clk); irq_in[0] = 1'b1;
        repeat (STAGES) @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 12'h280; bus_wdata = 32'h00000000;
        @(posedge clk);
        @(negedge clk); bus_wr = 1'b0;
        settle();
        @(negedge clk); check("R7 edge wins", {31'd0, irq_out[0]}, 32'h1);
        wr(12'h280, 32'h00000000); settle();
        @(negedge clk); check("R6 clear after R7", {31'd0, irq_out[0]}, 32'h0);

        // R1: reset again
        @(negedge clk); rst_n = 1'b0;
        #1;
        check("R1 outputs", irq_out[31:0], 32'h0);
        rd_chk("R1 mask", 12'h400, 32'h0);
        rd_chk("R1 mode", 12'h180, 32'h0);
        rst_n = 1'b1;
        settle();
        finish_up();
    end

endmodule